// File: doc/BRIEF.md
# Excluded-Set Tag Picker

This block picks a 4-bit tag for a tagged pointer. On a request it chooses an offset and a start tag. It then walks around the 16 tag values, modulo 16, until it lands on a tag that a 16-bit exclusion mask permits. The walk examines one candidate per clock, so the time to an answer depends on how dense the mask is and how large the offset is.

The block has two modes. In the random mode, the offset is four bits drawn from a 16-bit LFSR seed supplied on a port. The exclusion mask is the OR of a configured mask and a per-request mask. The result is recorded in a packed state word together with the advanced seed. In the step mode, the start tag comes from the pointer's tag field and the offset comes from a port. Only the configured mask applies, and the packed state word is not touched.

A one-cycle done pulse marks the cycle in which the chosen tag becomes valid. The caller waits for that pulse before it issues the next request.

Top module: `tag_pick`

## Requirements
- R1: After reset, `tag_o` and `state_o` are zero and `done_o` is low.
- R2: When the effective exclusion mask is all ones, the result tag is 0, whatever the start and offset. `done_o` rises on the same clock edge that accepts the request.
- R3: With offset 0, the result is the first tag at or after the start tag, counting upward modulo 16, whose mask bit is 0. Bit n of a mask excludes tag n.
- R4: With a nonzero offset k, the following step is repeated k times: move up by one modulo 16 at least once, then keep moving while the tag is excluded. The tag reached after the last step is the result.
- R5: The random offset is made from four LFSR steps. Each step forms a bit as seed[5]^seed[3]^seed[2]^seed[0], then replaces the seed with {bit, seed[15:1]}. The first bit produced becomes offset bit 0 and the fourth becomes offset bit 3.
- R6: In the random mode, the start tag is `start_tag_i` and the mask is `cfg_mask_i | req_mask_i`. On completion, `state_o` holds the advanced seed in bits 23:8, zero in bits 7:4 and the chosen tag in bits 3:0.
- R7: In the step mode (`step_i`=1), the start tag is `ptr_i[59:56]`, the offset is `step_off_i` and the mask is `cfg_mask_i` alone. `start_tag_i`, `seed_i` and `req_mask_i` have no effect, and `state_o` is left unchanged.
- R8: `done_o` is high for exactly one cycle per request, and `tag_o` holds the result until the next completion. With no excluded tags, `done_o` rises k+1 edges after the accepting edge. The latency never exceeds 16*k+16 edges.
- R9: A request that arrives while a walk is in progress is ignored. It changes neither the result in flight nor the outputs afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when idle |
| step_i | input | 1 | 1 selects the step mode, 0 the random mode |
| start_tag_i | input | 4 | Start tag for the random mode |
| ptr_i | input | 64 | Pointer; bits 59:56 give the step-mode start tag |
| step_off_i | input | 4 | Offset for the step mode |
| seed_i | input | 16 | LFSR seed for the random mode |
| cfg_mask_i | input | 16 | Configured exclusion mask |
| req_mask_i | input | 16 | Per-request exclusion mask (random mode only) |
| tag_o | output | 4 | Chosen tag |
| state_o | output | 24 | Packed seed and tag after a random draw |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench targets wrap-around at tag 15 and the difference between offset 0 and offset 1 when the start tag is itself allowed. A design that gets the first wrong would stick at 15 or pick tag 0 by mistake. A design that gets the second wrong would return the start tag where one step was owed.

It sweeps sparse masks that leave one tag open. In these cases a walk bound that is too tight would give a wrong tag, and a missing all-ones guard would hang. It also checks the bit order of the LFSR offset: a reversed order shows up as a wrong tag or a wrong packed seed.

Step-mode requests carry deliberately conflicting values on the ignored inputs, and a second request is fired into a walk in progress. A design that leaks either one changes the tag or `state_o`.

// File: rtl/tag_pick.sv
module tag_pick #(
  parameter int TAG_W   = 4,
  parameter int SEED_W  = 16,
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic                    step_i,
  input  logic [TAG_W-1:0]        start_tag_i,
  input  logic [PTR_W-1:0]        ptr_i,
  input  logic [TAG_W-1:0]        step_off_i,
  input  logic [SEED_W-1:0]       seed_i,
  input  logic [(1<<TAG_W)-1:0]   cfg_mask_i,
  input  logic [(1<<TAG_W)-1:0]   req_mask_i,
  output logic [TAG_W-1:0]        tag_o,
  output logic [SEED_W+7:0]       state_o,
  output logic                    done_o
);
  localparam int NTAG = 1 << TAG_W;
  localparam int PADW = 8 - TAG_W;
  localparam int CW   = $clog2(NTAG * NTAG + NTAG + 1);

  typedef enum logic {IDLE, WALK} st_t;
  st_t st_q;

  logic [TAG_W-1:0]  cur_q, rem_q, off_q;
  logic [NTAG-1:0]   msk_q;
  logic              rnd_q;
  logic [SEED_W-1:0] seed_q, seed_nxt;
  logic [TAG_W-1:0]  roff;
  logic              fb;
  logic [CW-1:0]     walk_cyc;

  always_comb begin
    seed_nxt = seed_i;
    roff     = '0;
    fb       = 1'b0;
    for (int i = 0; i < TAG_W; i++) begin
      fb       = seed_nxt[5] ^ seed_nxt[3] ^ seed_nxt[2] ^ seed_nxt[0];
      roff[i]  = fb;
      seed_nxt = {fb, seed_nxt[SEED_W-1:1]};
    end
  end

  wire [TAG_W-1:0] start_sel = step_i ? ptr_i[TAG_LSB +: TAG_W] : start_tag_i;
  wire [TAG_W-1:0] off_sel   = step_i ? step_off_i : roff;
  wire [NTAG-1:0]  mask_sel  = step_i ? cfg_mask_i : (cfg_mask_i | req_mask_i);
  wire             accept    = req_i && (st_q == IDLE);
  wire [TAG_W-1:0] nxt_tag   = cur_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      off_q   <= '0;
      msk_q   <= '0;
      rnd_q   <= 1'b0;
      seed_q  <= '0;
      tag_o   <= '0;
      state_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        IDLE: if (accept) begin
          msk_q  <= mask_sel;
          rnd_q  <= !step_i;
          seed_q <= seed_nxt;
          off_q  <= off_sel;
          if (&mask_sel) begin
            tag_o  <= '0;
            done_o <= 1'b1;
            if (!step_i) state_o <= {seed_nxt, {PADW{1'b0}}, {TAG_W{1'b0}}};
          end else begin
            cur_q <= start_sel;
            rem_q <= off_sel;
            st_q  <= WALK;
          end
        end
        WALK: begin
          if (rem_q == '0) begin
            if (msk_q[cur_q]) begin
              cur_q <= nxt_tag;
            end else begin
              tag_o  <= cur_q;
              done_o <= 1'b1;
              st_q   <= IDLE;
              if (rnd_q) state_o <= {seed_q, {PADW{1'b0}}, cur_q};
            end
          end else begin
            cur_q <= nxt_tag;
            if (!msk_q[nxt_tag]) rem_q <= rem_q - 1'b1;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  // cycle counter used only by the latency-bound assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              walk_cyc <= '0;
    else if (accept)         walk_cyc <= '0;
    else if (st_q == WALK)   walk_cyc <= walk_cyc + 1'b1;
  end

  assert_tag_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((&msk_q) ? (tag_o == '0) : !msk_q[tag_o]));

  assert_walk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK) |-> (int'(walk_cyc) <= NTAG * int'(off_q) + NTAG - 1));

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(st_q == WALK || (req_i && st_q == IDLE)));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK) |=> ($stable(msk_q) && $stable(off_q) && $stable(rnd_q)));

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rnd_q) |-> $stable(state_o));
endmodule

// File: tb/tag_pick_tb.sv
module tag_pick_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, step_i = 1'b0;
  logic [3:0]  start_tag_i = '0, step_off_i = '0;
  logic [63:0] ptr_i = '0;
  logic [15:0] seed_i = '0, cfg_mask_i = '0, req_mask_i = '0;
  logic [3:0]  tag_o;
  logic [23:0] state_o;
  logic        done_o;

  int nchk = 0, nfail = 0;
  logic [23:0] exp_state = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  tag_pick u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .step_i(step_i),
    .start_tag_i(start_tag_i), .ptr_i(ptr_i), .step_off_i(step_off_i),
    .seed_i(seed_i), .cfg_mask_i(cfg_mask_i), .req_mask_i(req_mask_i),
    .tag_o(tag_o), .state_o(state_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_pick(input logic [3:0] st, input logic [3:0] off,
                                          input logic [15:0] m);
    logic [3:0] t;
    if (m == 16'hFFFF) return 4'h0;
    t = st;
    if (off == 0) begin
      for (int j = 0; j < 16 && m[t]; j++) t = t + 1'b1;
    end else begin
      for (int k = 0; k < off; k++) begin
        t = t + 1'b1;
        for (int j = 0; j < 16 && m[t]; j++) t = t + 1'b1;
      end
    end
    return t;
  endfunction

  task automatic ref_lfsr(input logic [15:0] s, output logic [3:0] off, output logic [15:0] ns);
    logic b;
    ns = s;
    for (int i = 0; i < 4; i++) begin
      b = ns[5] ^ ns[3] ^ ns[2] ^ ns[0];
      off[i] = b;
      ns = {b, ns[15:1]};
    end
  endtask

  task automatic do_req(input logic stp, input logic [3:0] st, input logic [3:0] ptag,
                        input logic [3:0] off, input logic [15:0] sd, input logic [15:0] cm,
                        input logic [15:0] rm, output logic [3:0] tg, output logic [23:0] sv,
                        output int lat);
    @(negedge clk);
    step_i = stp; start_tag_i = st; ptr_i = {4'hA, ptag, 56'h0123456789ABCD};
    step_off_i = off; seed_i = sd; cfg_mask_i = cm; req_mask_i = rm; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check(done_o, "R8 done seen", done_o, 1);
    tg = tag_o;
    sv = state_o;
    @(negedge clk);
    check(!done_o, "R8 single-cycle done", done_o, 0);
    check(tag_o == tg, "R8 tag held", tag_o, tg);
  endtask

  initial begin
    logic [3:0]  tg, eo, et;
    logic [23:0] sv;
    logic [15:0] ns, sd;
    int lat;
    logic [15:0] smask [7] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'hFFFE,
                               16'h8001, 16'hAAAA, 16'h1248};
    logic [15:0] cms [3] = '{16'h0000, 16'h00F0, 16'hFF00};
    logic [15:0] rms [3] = '{16'h0000, 16'h0F00, 16'h00FF};
    logic [15:0] seeds [5] = '{16'h0001, 16'hACE1, 16'h0000, 16'hFFFF, 16'h5A3C};

    repeat (3) @(negedge clk);
    check(tag_o == 0, "R1 reset tag", tag_o, 0);
    check(state_o == 0, "R1 reset state", state_o, 0);
    check(!done_o, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 first requests after reset: R6 and R7 cover state, R2-R4 the search
    foreach (smask[mi]) begin
      for (int s = 0; s < 16; s++) begin
        for (int o = 0; o < 16; o++) begin
          // R7: conflicting start_tag_i, seed_i, req_mask_i must not matter
          do_req(1'b1, ~s[3:0], s[3:0], o[3:0], 16'hBEEF, smask[mi], ~smask[mi], tg, sv, lat);
          et = ref_pick(s[3:0], o[3:0], smask[mi]);
          if (smask[mi] == 16'hFFFF) begin
            check(tg == 0, "R2 all-ones tag", tg, 0);
            check(lat == 0, "R2 same-edge done", lat, 0);
          end else if (o == 0) begin
            check(tg == et, "R3 zero-offset tag", tg, et);
          end else begin
            check(tg == et, "R4 stepped tag", tg, et);
          end
          check(sv == exp_state, "R7 state unchanged", sv, exp_state);
          if (smask[mi] == 16'h0000)
            check(lat == o + 1, "R8 unexcluded latency", lat, o + 1);
          check(lat <= 16 * o + 16, "R8 latency bound", lat, 16 * o + 16);
        end
      end
    end

    foreach (seeds[si]) begin
      sd = seeds[si];
      foreach (cms[ci]) begin
        for (int s = 0; s < 16; s++) begin
          ref_lfsr(sd, eo, ns);
          // ptr and step_off_i carry junk in the random mode
          do_req(1'b0, s[3:0], ~s[3:0], ~eo, sd, cms[ci], rms[ci], tg, sv, lat);
          et = ref_pick(s[3:0], eo, cms[ci] | rms[ci]);
          check(tg == et, "R5 random-offset tag", tg, et);
          exp_state = {ns, 4'h0, et};
          check(sv == exp_state, "R6 packed state", sv, exp_state);
          sd = ns;
        end
      end
    end

    // R9: second request fired into a long walk
    @(negedge clk);
    step_i = 1'b1; ptr_i = {4'h0, 4'h0, 56'h0}; step_off_i = 4'd15;
    cfg_mask_i = 16'h7FFF; req_mask_i = 16'h0; seed_i = 16'h1234; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    step_i = 1'b0; cfg_mask_i = 16'hFFFF; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check(tag_o == 4'hF, "R9 in-flight result kept", tag_o, 4'hF);
    check(state_o == exp_state, "R9 state untouched", state_o, exp_state);
    lat = 0;
    repeat (20) begin
      @(negedge clk);
      if (done_o) lat++;
    end
    check(lat == 0, "R9 no extra done", lat, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule